// File: doc/BRIEF.md
# Respiration Carrier and Demodulation Clock Generator

This block drives an impedance-based breathing measurement. It makes a square-wave carrier on two output pins that are always in opposite states, so an external network can push a small alternating current through the body. It also makes a demodulation reference clock at the same frequency. That clock lags the carrier by a programmable fraction of a period. The lag compensates for the rounding and delay that cable capacitance and amplifier bandwidth add to the received carrier, so the synchronous detector samples at the right instant.

All timing comes from one master clock. A prescaler divides the master clock to sixteen steps per carrier period. A step counter sets both the carrier and the demodulation clock, and the demodulation clock uses a shifted tap of that counter. Two carrier rates are available, one twice the other. The phase code gives a lag of code × 22.5 degrees, which is one step for each code unit.

Internal generation runs only when the two-bit source field selects internal clocking. The carrier pins and the demodulation clock each have their own enable. A new phase code or rate is held until the current carrier period ends, so a period is never cut short or stretched in the middle.

Top module: `respModGen`

## Requirements
- R1: While reset is asserted, and after reset with no internal generation selected, `modPos`, `modNeg` and `demodClk` are all low.
- R2: With `freqSel`=0 the carrier period is 16×DIV_SLOW master cycles, and with `freqSel`=1 it is 16×DIV_FAST master cycles. `modPos` is high for exactly half of each period.
- R3: While generation is active with `modEn`=1, `modNeg` is the complement of `modPos` on every cycle. The two pins are never high together.
- R4: With `modEn`=0, both carrier pins are low from the first clock edge that samples it. A running demodulation clock is not disturbed.
- R5: With `demodEn`=0, `demodClk` is low from the first clock edge that samples it. While `demodEn`=1, `demodClk` has the same period and 50 % duty as the carrier, whether or not `modEn` is set.
- R6: The rising edge of `demodClk` follows the rising edge of `modPos` by `phaseCode` × (period/16) master cycles. Code 0 gives coincident edges, and code 7 gives 157.5 degrees.
- R7: Only `srcMode`=2'b10 generates clocks. Values 2'b00, 2'b01 and 2'b11, or both enables low, drive all three outputs low from the next clock edge.
- R8: A change of `phaseCode` or `freqSel` while generation is running takes effect only at the next carrier period boundary. The period in progress keeps its old lag and length.
- R9: When generation becomes active, `modPos` is low after the first edge that samples the activation and high after the second. The first period uses the `phaseCode` and `freqSel` sampled at activation and has full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| modEn | input | 1 | Enables the carrier pins |
| demodEn | input | 1 | Enables the demodulation clock |
| srcMode | input | 2 | Clock source; 2'b10 = internal generation |
| freqSel | input | 1 | 0 = slower carrier, 1 = carrier at twice the rate |
| phaseCode | input | PHASE_W | Demodulation lag in sixteenths of a period |
| modPos | output | 1 | Carrier, high during the first half period |
| modNeg | output | 1 | Carrier complement |
| demodClk | output | 1 | Delayed demodulation reference |

## Verification
The bench builds the block with DIV_SLOW=4, DIV_FAST=2 and PHASE_W=3. This gives carrier periods of 64 and 32 master cycles and lag steps of 4 and 2 cycles. Because the periods are short, the random loop can cover every phase code at both rates, each measured edge to edge, within a few thousand cycles. Directed cases change the code and the rate in the middle of a period to show the deferral, and they step through every idle source value and enable combination.

// File: rtl/respModPkg.sv
package respModPkg;
  // Source-field value that selects internally generated clocks
  localparam logic [1:0] SRC_INTERNAL = 2'b10;

  // Strobes from the sequencer to the waveform datapath
  typedef struct packed {
    logic clear;    // hold step counter at zero
    logic step;     // advance one sixteenth of a period
    logic modOn;    // carrier pins may drive
    logic demodOn;  // demodulation clock may drive
  } seqStrobe_t;
endpackage

// File: rtl/respModCtrl.sv
module respModCtrl
  import respModPkg::*;
#(
  parameter int DIV_SLOW = 4,
  parameter int DIV_FAST = 2,
  parameter int PHASE_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modEn,
  input  logic               demodEn,
  input  logic [1:0]         srcMode,
  input  logic               freqSel,
  input  logic [PHASE_W-1:0] phaseCode,
  input  logic [PHASE_W:0]   phaseIdx,
  output seqStrobe_t         strobes,
  output logic [PHASE_W-1:0] lagSteps
);
  localparam int IDX_W   = PHASE_W + 1;
  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int PRE_W   = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;

  logic [PRE_W-1:0]   presc;
  logic [PRE_W-1:0]   divLast;
  logic               runQ;
  logic               fastQ;
  logic [PHASE_W-1:0] lagQ;
  logic               run;
  logic               live;
  logic               stepNow;
  logic               wrap;

  always_comb begin
    run     = (srcMode == SRC_INTERNAL) && (modEn || demodEn);
    live    = run && runQ;
    divLast = fastQ ? PRE_W'(DIV_FAST - 1) : PRE_W'(DIV_SLOW - 1);
    stepNow = live && (presc == divLast);
    wrap    = stepNow && (phaseIdx == {IDX_W{1'b1}});
    strobes.clear   = !live;
    strobes.step    = stepNow;
    strobes.modOn   = live && modEn;
    strobes.demodOn = live && demodEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      presc <= '0;
      fastQ <= 1'b0;
      lagQ  <= '0;
    end else begin
      runQ <= run;
      if (!live || stepNow) presc <= '0;
      else                  presc <= presc + 1'b1;
      // configuration is taken at start-up or at a period boundary only
      if (!runQ || wrap) begin
        fastQ <= freqSel;
        lagQ  <= phaseCode;
      end
    end
  end

  assign lagSteps = lagQ;

  // R2: the prescaler never runs past the divide selected for this period
  a_r2_presc_bound: assert property (@(posedge clk) disable iff (!rstN)
    presc <= divLast);

  // R8: rate and lag stay put inside a running period
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    (live && !wrap) |=> ($stable(lagQ) && $stable(fastQ)));
endmodule

// File: rtl/respModPath.sv
module respModPath
  import respModPkg::*;
#(
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobes,
  input  logic [PHASE_W-1:0] lagSteps,
  output logic [PHASE_W:0]   phaseIdx,
  output logic               modPos,
  output logic               modNeg,
  output logic               demodClk
);
  localparam int IDX_W = PHASE_W + 1;

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] demodIdx;
  logic             carrierHigh;
  logic             demodHigh;

  always_comb begin
    carrierHigh = !idx[IDX_W-1];
    demodIdx    = idx - IDX_W'(lagSteps);
    demodHigh   = !demodIdx[IDX_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx      <= '0;
      modPos   <= 1'b0;
      modNeg   <= 1'b0;
      demodClk <= 1'b0;
    end else begin
      if (strobes.clear)     idx <= '0;
      else if (strobes.step) idx <= idx + 1'b1;
      modPos   <= strobes.modOn && carrierHigh;
      modNeg   <= strobes.modOn && !carrierHigh;
      demodClk <= strobes.demodOn && demodHigh;
    end
  end

  assign phaseIdx = idx;

  // R3: carrier pins never overlap
  a_r3_antiphase: assert property (@(posedge clk) disable iff (!rstN)
    !(modPos && modNeg));

  // R6: the step index moves only on a step strobe or a clear
  a_r6_idx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.step && !strobes.clear) |=> $stable(idx));
endmodule

// File: rtl/respModGen.sv
module respModGen
  import respModPkg::*;
#(
  parameter int DIV_SLOW = 4,
  parameter int DIV_FAST = 2,
  parameter int PHASE_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modEn,
  input  logic               demodEn,
  input  logic [1:0]         srcMode,
  input  logic               freqSel,
  input  logic [PHASE_W-1:0] phaseCode,
  output logic               modPos,
  output logic               modNeg,
  output logic               demodClk
);
  seqStrobe_t         strobes;
  logic [PHASE_W-1:0] lagSteps;
  logic [PHASE_W:0]   phaseIdx;

  respModCtrl #(
    .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .PHASE_W(PHASE_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .modEn(modEn), .demodEn(demodEn),
    .srcMode(srcMode), .freqSel(freqSel), .phaseCode(phaseCode),
    .phaseIdx(phaseIdx), .strobes(strobes), .lagSteps(lagSteps)
  );

  respModPath #(.PHASE_W(PHASE_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lagSteps(lagSteps),
    .phaseIdx(phaseIdx), .modPos(modPos), .modNeg(modNeg),
    .demodClk(demodClk)
  );

  // R7: any non-internal source value idles every output at the next edge
  a_r7_idle: assert property (@(posedge clk) disable iff (!rstN)
    (srcMode != SRC_INTERNAL) |=> (!modPos && !modNeg && !demodClk));

  // R4: carrier enable low silences both pins
  a_r4_mod_gate: assert property (@(posedge clk) disable iff (!rstN)
    !modEn |=> (!modPos && !modNeg));

  // R5: demodulation enable low silences the reference clock
  a_r5_demod_gate: assert property (@(posedge clk) disable iff (!rstN)
    !demodEn |=> !demodClk);
endmodule

// File: tb/respModGen_test.sv
module respModGen_test;
  localparam int DS = 4;
  localparam int DF = 2;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          modEn = 1'b0;
  logic          demodEn = 1'b0;
  logic [1:0]    srcMode = 2'b00;
  logic          freqSel = 1'b0;
  logic [PW-1:0] phaseCode = '0;
  logic          modPos, modNeg, demodClk;

  int  checks = 0;
  int  errors = 0;
  int  wd = 0;
  bit  pMod = 1'b0;
  bit  pDem = 1'b0;

  respModGen #(.DIV_SLOW(DS), .DIV_FAST(DF), .PHASE_W(PW)) uut (
    .clk(clk), .rstN(rstN), .modEn(modEn), .demodEn(demodEn),
    .srcMode(srcMode), .freqSel(freqSel), .phaseCode(phaseCode),
    .modPos(modPos), .modNeg(modNeg), .demodClk(demodClk)
  );

  always #2 clk = ~clk;

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog all requirements actual %0d expected <150000", wd);
      summary();
      $finish;
    end
  end

  function automatic int expDiv(input bit fast);
    return fast ? DF : DS;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    pMod = modPos;
    pDem = demodClk;
    @(negedge clk);
  endtask

  task automatic waitModRise();
    do tick(); while (!(!pMod && modPos));
  endtask

  // Called at a modPos rise sample; runs to the next rise sample
  task automatic measure(output int period, output int highLen,
                         output int lag, output int mism);
    int n;
    bit gotLag;
    n = 0; highLen = 1; lag = -1; mism = 0; gotLag = 0;
    if (modNeg == modPos) mism++;
    if (!pDem && demodClk) begin lag = 0; gotLag = 1; end
    forever begin
      tick();
      n++;
      if (modNeg == modPos) mism++;
      if (!gotLag && !pDem && demodClk) begin lag = n; gotLag = 1; end
      if (!pMod && modPos) break;
      if (modPos) highLen++;
    end
    period = n;
  endtask

  task automatic countHighs(input int len, output int mH, output int nH, output int dH);
    mH = 0; nH = 0; dH = 0;
    for (int i = 0; i < len; i++) begin
      tick();
      if (modPos) mH++;
      if (modNeg) nH++;
      if (demodClk) dH++;
    end
  endtask

  task automatic goIdle();
    srcMode = 2'b00;
    tick(); tick();
  endtask

  initial begin
    int per, hi, lag, mism, mH, nH, dH;
    bit f;
    int code;
    void'($urandom(32'd20240611));

    // R1: reset state
    repeat (4) tick();
    chk(!modPos && !modNeg && !demodClk, "R1 outputs low in reset",
        int'(modPos) + int'(modNeg) + int'(demodClk), 0);
    rstN = 1'b1;
    modEn = 1'b1; demodEn = 1'b1;
    tick(); tick();
    chk(!modPos && !modNeg && !demodClk, "R1 outputs low after reset, idle source",
        int'(modPos) + int'(modNeg) + int'(demodClk), 0);

    // R9: activation start-up timing and a full first period
    freqSel = 1'b0; phaseCode = 3'd3;
    srcMode = 2'b10;
    tick();
    chk(!modPos, "R9 modPos low after first edge", int'(modPos), 0);
    tick();
    chk(modPos && !modNeg, "R9 modPos high after second edge", int'(modPos), 1);
    measure(per, hi, lag, mism);
    chk(per == 16 * DS, "R9 first period length", per, 16 * DS);
    chk(lag == 3 * DS, "R9 first period uses sampled code", lag, 3 * DS);

    // R8: phase code change mid-period deferred to the boundary
    goIdle();
    freqSel = 1'b0; phaseCode = 3'd2;
    srcMode = 2'b10;
    waitModRise();
    phaseCode = 3'd6;
    measure(per, hi, lag, mism);
    chk(lag == 2 * DS, "R8 old lag kept in current period", lag, 2 * DS);
    measure(per, hi, lag, mism);
    chk(lag == 6 * DS, "R8 new lag after boundary", lag, 6 * DS);

    // R8: rate change mid-period deferred to the boundary
    phaseCode = 3'd0;
    waitModRise();
    freqSel = 1'b1;
    measure(per, hi, lag, mism);
    chk(per == 16 * DS, "R8 old period kept", per, 16 * DS);
    measure(per, hi, lag, mism);
    chk(per == 16 * DF, "R8 new period after boundary", per, 16 * DF);
    chk(hi == 8 * DF, "R2 fast half period", hi, 8 * DF);

    // R7: leaving internal mode idles outputs at the next edge
    srcMode = 2'b01;
    tick();
    chk(!modPos && !modNeg && !demodClk, "R7 idle at next edge",
        int'(modPos) + int'(modNeg) + int'(demodClk), 0);
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      srcMode = 2'(m);
      tick(); tick();
      countHighs(64, mH, nH, dH);
      chk(mH + nH + dH == 0, $sformatf("R7 source %0d stays idle", m), mH + nH + dH, 0);
    end
    srcMode = 2'b10; modEn = 1'b0; demodEn = 1'b0;
    tick(); tick();
    countHighs(64, mH, nH, dH);
    chk(mH + nH + dH == 0, "R7 both enables low idles", mH + nH + dH, 0);

    // R4: carrier off, demodulation clock keeps running
    goIdle();
    freqSel = 1'b0; phaseCode = 3'd5;
    modEn = 1'b0; demodEn = 1'b1; srcMode = 2'b10;
    tick(); tick(); tick();
    countHighs(16 * DS, mH, nH, dH);
    chk(mH + nH == 0, "R4 carrier pins silent", mH + nH, 0);
    chk(dH == 8 * DS, "R5 demod runs without carrier", dH, 8 * DS);
    modEn = 1'b1;
    tick(); tick();
    modEn = 1'b0;
    tick();
    chk(!modPos && !modNeg, "R4 carrier drops at next edge", int'(modPos) + int'(modNeg), 0);

    // R5: demodulation off, carrier runs
    goIdle();
    modEn = 1'b1; demodEn = 1'b0; srcMode = 2'b10;
    tick(); tick(); tick();
    countHighs(16 * DS, mH, nH, dH);
    chk(dH == 0, "R5 demod silent when disabled", dH, 0);
    chk(mH == 8 * DS && nH == 8 * DS, "R3 complementary halves", mH, 8 * DS);

    // Random configurations: R2, R3, R6
    for (int it = 0; it < 40; it++) begin
      goIdle();
      f = 1'($urandom % 2);
      code = int'($urandom % 8);
      if (it < 16) begin f = it[3]; code = it % 8; end
      freqSel = f; phaseCode = 3'(code);
      modEn = 1'b1; demodEn = 1'b1; srcMode = 2'b10;
      waitModRise();
      measure(per, hi, lag, mism);
      chk(per == 16 * expDiv(f), "R2 period", per, 16 * expDiv(f));
      chk(hi == 8 * expDiv(f), "R2 half period high", hi, 8 * expDiv(f));
      chk(lag == code * expDiv(f), "R6 demod lag", lag, code * expDiv(f));
      chk(mism == 0, "R3 antiphase every cycle", mism, 0);
    end

    summary();
    $finish;
  end
endmodule